// File: doc/BRIEF.md
# DRAM Refresh Slot Scheduler

This block decides, once per scanline, when the CPU side must pause for a DRAM refresh. It watches the horizontal master-clock count supplied by the video timing logic. When that count reaches the refresh slot chosen for the current line, the block raises a stall signal for a fixed window that is a whole number of 8-clock grid units long. The memory arbiter uses that signal to hold off CPU bus cycles.

Two behaviours are selectable. The steady mode places the refresh at the same horizontal position on every line. The alternating mode swaps between an early and a late position on successive lines. The alternation phase is kept in a register that flips at every line start, whichever mode is selected. After reset that phase is defined, so the first line that begins after reset always gets the late slot. The short-line flag from the timing logic is accepted but changes nothing: neither mode moves its slot on a shortened line. A debug code output shows which slot applies to the line in progress.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset `refresh_stall` is 0, and no refresh is issued until the first `line_start` pulse after reset has been sampled.
- R2: With `rev_sel` = 0 (steady mode), `refresh_stall` rises on the clock edge that samples `hcount` = 528, on every line.
- R3: With `rev_sel` = 1 (alternating mode), the refresh starts at `hcount` = 536 on lines with an odd count of line starts since reset, and at 532 on lines with an even count. The first line after reset therefore uses 536.
- R4: Each refresh holds `refresh_stall` high for exactly 40 consecutive clock cycles, which is 5 units of the 8-clock grid.
- R5: The alternation phase flips at every sampled `line_start` in both modes. A switch from steady to alternating mode continues that phase and does not restart it.
- R6: At most one refresh is issued per line. The trigger is an exact match on `hcount`, so a count that returns to the slot position within the same line issues no second refresh.
- R7: `short_line` has no effect on the slot position or the stall window in either mode.
- R8: `slot_code` reads 0 in steady mode (position 528), 1 for the early slot (532) and 2 for the late slot (536) in alternating mode. It reflects the phase of the line in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| hcount | input | 11 | Horizontal position in master clocks within the line |
| line_start | input | 1 | One-cycle pulse at the start of each scanline |
| short_line | input | 1 | Marks a shortened scanline; has no effect |
| rev_sel | input | 1 | 0 = steady slot, 1 = alternating slot |
| refresh_stall | output | 1 | High while the CPU side must be held for refresh |
| slot_code | output | 2 | Debug: slot in use on the current line |

## Verification
The hardest situation to reach from the ports is a second arrival at the slot position within one line, because a real counter never goes backwards. The bench drives `hcount` directly. After a refresh it rewinds the count across the slot without a line start and expects no stall. A second hard case is the phase restart: the bench applies reset in the middle of a run and confirms that the next line uses the late slot again. It also switches modes between lines so that the steady lines are seen to advance the phase.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    // Debug code for the slot applied to the current line
    typedef enum logic [1:0] {
        SLOT_FIXED = 2'd0,
        SLOT_EARLY = 2'd1,
        SLOT_LATE  = 2'd2
    } slot_e;

    typedef enum logic {
        MODE_STEADY    = 1'b0,
        MODE_ALTERNATE = 1'b1
    } mode_e;

    // Line phase state
    typedef struct packed {
        logic armed;   // at least one line start seen since reset
        logic late;    // alternating mode uses the late slot on this line
    } phase_s;

    function automatic slot_e pick_slot(input mode_e mode, input logic late);
        if (mode == MODE_STEADY)
            return SLOT_FIXED;
        return late ? SLOT_LATE : SLOT_EARLY;
    endfunction

endpackage

// File: rtl/refresh_phase_track.sv
module refresh_phase_track
    import dram_refresh_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   line_start,
    output phase_s phase
);
    phase_s phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '{armed: 1'b0, late: 1'b0};
        end else if (line_start) begin
            phase_q.armed <= 1'b1;
            phase_q.late  <= ~phase_q.late;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/refresh_slot_match.sv
module refresh_slot_match
    import dram_refresh_pkg::*;
#(
    parameter int HC_W      = 11,
    parameter int POS_FIXED = 528,
    parameter int POS_EARLY = 532,
    parameter int POS_LATE  = 536
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HC_W-1:0] hcount,
    input  logic            line_start,
    input  phase_s          phase,
    input  mode_e           mode,
    output slot_e           slot,
    output logic            fire
);
    localparam logic [HC_W-1:0] P_FIXED = HC_W'(POS_FIXED);
    localparam logic [HC_W-1:0] P_EARLY = HC_W'(POS_EARLY);
    localparam logic [HC_W-1:0] P_LATE  = HC_W'(POS_LATE);

    logic [HC_W-1:0] target;
    logic            done_q;

    always_comb begin
        slot = pick_slot(mode, phase.late);
        unique case (slot)
            SLOT_EARLY: target = P_EARLY;
            SLOT_LATE:  target = P_LATE;
            default:    target = P_FIXED;
        endcase
    end

    assign fire = phase.armed && !done_q && !line_start && (hcount == target);

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else if (line_start)
            done_q <= 1'b0;
        else if (fire)
            done_q <= 1'b1;
    end
endmodule

// File: rtl/refresh_stall_timer.sv
module refresh_stall_timer #(
    parameter int GRID  = 8,
    parameter int UNITS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic stall
);
    localparam int PW = (GRID  > 1) ? $clog2(GRID)  : 1;
    localparam int UW = (UNITS > 1) ? $clog2(UNITS) : 1;
    localparam logic [PW-1:0] PRE_LAST  = PW'(GRID - 1);
    localparam logic [UW-1:0] UNIT_LAST = UW'(UNITS - 1);

    logic          stall_q;
    logic [PW-1:0] pre_q;
    logic [UW-1:0] unit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= 1'b0;
            pre_q   <= '0;
            unit_q  <= '0;
        end else if (fire) begin
            stall_q <= 1'b1;
            pre_q   <= '0;
            unit_q  <= '0;
        end else if (stall_q) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                if (unit_q == UNIT_LAST) begin
                    stall_q <= 1'b0;
                    unit_q  <= '0;
                end else begin
                    unit_q <= unit_q + 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign stall = stall_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_refresh_pkg::*;
#(
    parameter int HC_W      = 11,
    parameter int POS_FIXED = 528,
    parameter int POS_EARLY = 532,
    parameter int POS_LATE  = 536,
    parameter int GRID      = 8,
    parameter int UNITS     = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HC_W-1:0] hcount,
    input  logic            line_start,
    input  logic            short_line,
    input  logic            rev_sel,
    output logic            refresh_stall,
    output logic [1:0]      slot_code
);
    phase_s phase;
    slot_e  slot;
    logic   fire;
    mode_e  mode;
    logic   short_line_unused;

    // The shortened line changes nothing in either mode
    assign short_line_unused = short_line;
    assign mode = mode_e'(rev_sel);

    refresh_phase_track u_phase (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .phase      (phase)
    );

    refresh_slot_match #(
        .HC_W      (HC_W),
        .POS_FIXED (POS_FIXED),
        .POS_EARLY (POS_EARLY),
        .POS_LATE  (POS_LATE)
    ) u_match (
        .clk        (clk),
        .rst        (rst),
        .hcount     (hcount),
        .line_start (line_start),
        .phase      (phase),
        .mode       (mode),
        .slot       (slot),
        .fire       (fire)
    );

    refresh_stall_timer #(
        .GRID  (GRID),
        .UNITS (UNITS)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .stall (refresh_stall)
    );

    assign slot_code = slot;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter int HC_W      = 11,
    parameter int POS_FIXED = 528,
    parameter int POS_EARLY = 532,
    parameter int POS_LATE  = 536,
    parameter int WINDOW    = 40
) (
    input logic            clk,
    input logic            rst,
    input logic [HC_W-1:0] hcount,
    input logic            line_start,
    input logic            short_line,
    input logic            rev_sel,
    input logic            refresh_stall,
    input logic [1:0]      slot_code
);
    logic [7:0] run_len;
    logic [1:0] rises;
    logic       seen_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len   <= '0;
            rises     <= '0;
            seen_line <= 1'b0;
        end else begin
            run_len <= refresh_stall ? ((run_len == 8'hFF) ? run_len : run_len + 8'd1) : 8'd0;
            if (line_start)
                rises <= '0;
            else if (refresh_stall && run_len == 8'd0 && rises != 2'd3)
                rises <= rises + 2'd1;
            if (line_start)
                seen_line <= 1'b1;
        end
    end

    // R1: nothing before the first line start
    a_r1_idle_before_line: assert property (@(posedge clk) disable iff (rst)
        !seen_line |-> !refresh_stall);

    // R2: steady mode starts at the fixed slot
    a_r2_steady_start: assert property (@(posedge clk) disable iff (rst)
        $rose(refresh_stall) && !$past(rev_sel) |-> $past(hcount) == HC_W'(POS_FIXED));

    // R3: alternating mode starts at the slot shown by the debug code
    a_r3_alt_start: assert property (@(posedge clk) disable iff (rst)
        $rose(refresh_stall) && $past(rev_sel) |->
            $past(hcount) == (($past(slot_code) == 2'd2) ? HC_W'(POS_LATE) : HC_W'(POS_EARLY)));

    // R4: window length
    a_r4_window_len: assert property (@(posedge clk) disable iff (rst)
        $fell(refresh_stall) |-> run_len == 8'(WINDOW));

    // R5: phase flips at every line start while alternating
    a_r5_phase_flip: assert property (@(posedge clk) disable iff (rst)
        line_start && rev_sel |=> !rev_sel || slot_code != $past(slot_code));

    // R6: one refresh per line
    a_r6_single_refresh: assert property (@(posedge clk) disable iff (rst)
        $rose(refresh_stall) |-> rises == 2'd0);

    // R8: debug code range
    a_r8_code_range: assert property (@(posedge clk) disable iff (rst)
        (rev_sel ? (slot_code != 2'd0) : (slot_code == 2'd0)) && slot_code != 2'd3);

    // R7: short flag on a line start does not stop the phase flip
    a_r7_short_no_effect: assert property (@(posedge clk) disable iff (rst)
        line_start && short_line && rev_sel |=> !rev_sel || slot_code != $past(slot_code));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .hcount        (hcount),
    .line_start    (line_start),
    .short_line    (short_line),
    .rev_sel       (rev_sel),
    .refresh_stall (refresh_stall),
    .slot_code     (slot_code)
);

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
    localparam int MAXH   = 700;
    localparam int WINDOW = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] hcount = '0;
    logic        line_start = 1'b0;
    logic        short_line = 1'b0;
    logic        rev_sel = 1'b0;
    logic        refresh_stall;
    logic [1:0]  slot_code;

    int tests = 0;
    int fails = 0;
    int lines = 0;   // line starts since last reset
    bit done  = 0;

    always #2.5 clk = ~clk;

    dram_refresh_sched u_dram_refresh_sched (
        .clk           (clk),
        .rst           (rst),
        .hcount        (hcount),
        .line_start    (line_start),
        .short_line    (short_line),
        .rev_sel       (rev_sel),
        .refresh_stall (refresh_stall),
        .slot_code     (slot_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int h, input logic ls);
        @(negedge clk);
        hcount     = 11'(h);
        line_start = ls;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        line_start = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        lines = 0;
    endtask

    // One full line; returns checks on slot code and on the stall pattern
    task automatic run_line(input logic rv, input logic sh, input bit revisit, input string req);
        int pos;
        int exp_code;
        int bad_h;
        int first_hi;
        bit late;
        @(negedge clk);
        rev_sel    = rv;
        short_line = sh;
        drive(0, 1'b1);
        lines++;
        late     = lines[0];
        pos      = rv ? (late ? 536 : 532) : 528;
        exp_code = rv ? (late ? 2 : 1) : 0;
        check(slot_code == 2'(exp_code), {req, " R8 slot_code"}, slot_code, exp_code);
        bad_h = -1;
        first_hi = -1;
        for (int h = 1; h <= MAXH; h++) begin
            logic exp;
            drive(h, 1'b0);
            exp = (h >= pos) && (h < pos + WINDOW);
            if (refresh_stall && first_hi < 0) first_hi = h;
            if (refresh_stall !== exp && bad_h < 0) bad_h = h;
        end
        check(first_hi == pos, {req, " start position"}, first_hi, pos);
        check(bad_h < 0, {req, " R4 window (first bad hcount)"}, bad_h, -1);
        if (revisit) begin
            int hi = 0;
            for (int h = pos - 4; h <= pos + 50; h++) begin
                drive(h, 1'b0);
                if (refresh_stall) hi++;
            end
            check(hi == 0, "R6 rewind issues no second refresh", hi, 0);
        end
        short_line = 1'b0;
    endtask

    initial begin
        int hi;
        do_reset();
        #1;
        check(refresh_stall == 1'b0, "R1 reset stall", refresh_stall, 0);
        // R1: sweep across all slots before any line start
        rev_sel = 1'b1;
        hi = 0;
        for (int h = 0; h <= MAXH; h++) begin
            drive(h, 1'b0);
            if (refresh_stall) hi++;
        end
        check(hi == 0, "R1 no refresh before first line start", hi, 0);
        // R3: alternating sequence from reset, first line late
        for (int i = 0; i < 6; i++)
            run_line(1'b1, 1'b0, 1'b0, "R3 alternating");
        // R7: short lines in alternating mode
        run_line(1'b1, 1'b1, 1'b0, "R7 short alt");
        run_line(1'b1, 1'b1, 1'b0, "R7 short alt");
        run_line(1'b1, 1'b0, 1'b0, "R3 after short");
        // R2 and R7: steady mode, including short lines
        run_line(1'b0, 1'b0, 1'b0, "R2 steady");
        run_line(1'b0, 1'b1, 1'b0, "R7 short steady");
        run_line(1'b0, 1'b1, 1'b0, "R7 short steady");
        run_line(1'b0, 1'b0, 1'b0, "R2 steady");
        run_line(1'b0, 1'b0, 1'b1, "R2 steady rewind");
        // R5: phase kept advancing through steady lines
        run_line(1'b1, 1'b0, 1'b0, "R5 switch to alternating");
        run_line(1'b1, 1'b0, 1'b1, "R5 alternating rewind");
        run_line(1'b1, 1'b0, 1'b0, "R5 alternating");
        // R3: reset mid run restarts at the late slot
        do_reset();
        #1;
        check(refresh_stall == 1'b0, "R1 stall after mid-run reset", refresh_stall, 0);
        run_line(1'b1, 1'b0, 1'b0, "R3 first line after reset");
        run_line(1'b1, 1'b0, 1'b0, "R3 second line after reset");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule